// File: doc/BRIEF.md
# Overflow-driven general purpose timer

This block is a 32-bit timer that counts upward and signals an event when the count passes all-ones. Software stores a starting count in the counter register, optionally stores a reload value, and then writes a control word. The control word has a run bit and an auto-reload bit. While the run bit is set, the counter advances by one on every clock. When it steps past all-ones, an overflow status bit is set. In auto-reload mode the counter then takes the reload value and keeps running. In one-shot mode it falls to zero and the run bit clears.

A wait of N ticks is therefore programmed as all-ones minus N. A repeating period of P ticks is programmed as all-ones minus (P - 1), written both to the reload register and to the counter before the run command. Software can stop the counter, read the frozen count, and later restart from that count. The interrupt output is the overflow status ANDed with an enable bit. The status bit is cleared by writing a one to it.

The register port is a simple synchronous one. A write is taken on the rising edge at which `sel` and `wr_en` are both high. Read data is a combinational function of `addr` and the current register state. The asynchronous reset input is released into the logic through a two-flop synchroniser.

Top module: `gpt_timer`

## Requirements
- R1: While reset is asserted, and after it is released, every register reads zero and `irq` is low. Assertion of reset clears the registers at once, without waiting for a clock.
- R2: While the run bit is set, the counter grows by exactly one per clock. While the run bit is clear, the counter holds its value, so repeated reads return the same frozen count.
- R3: When the counter is at all-ones with the run bit set, the overflow status bit (bit 0 of the status register) reads 1 after the next clock edge.
- R4: With auto-reload set (control bit 1), the clock edge that overflows the counter loads it from the reload register. The run bit stays set.
- R5: With auto-reload clear, the clock edge that overflows the counter sets it to zero and clears the run bit (control bit 0). The control register then reads 0.
- R6: Suppose the counter holds all-ones minus N and the run bit is written at edge E0. The status bit then still reads 0 after edge EN and reads 1 after edge EN+1.
- R7: With auto-reload set, and with the reload value and the initial count both set to all-ones minus (P - 1), the counter returns to the reload value every P clocks.
- R8: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged.
- R9: If a write that clears the status bit lands on the same edge as a new overflow, the status bit reads 1.
- R10: `irq` is high exactly when the status bit and the enable bit (bit 0 at offset 0x10) are both 1.
- R11: A counter write at offset 0x08 sets the count on that edge, whether the counter is stopped or running. Such a write wins over the increment. On an overflow edge it also cancels that overflow, so the status bit is not set.
- R12: The register offsets are: control at 0x00, reload at 0x04, counter at 0x08, status at 0x0C and enable at 0x10. Any other address reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the counting tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Register access select |
| wr_en | input | 1 | Write strobe, qualified by `sel` |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Overflow interrupt, level |

## Verification
Every register write takes effect on the edge it lands on. The bench drives inputs just after a falling edge and reads back at the following falling edge. A run command at edge E0 leaves the count unchanged at that edge, and the first increment lands on E1. The overflow status for a starting count of all-ones minus N is therefore due exactly after edge N+1, and the bench checks for 0 one cycle earlier and for 1 on that cycle. Because `rdata` and `irq` are combinational from registers, each check of them is made one time step after the address is driven, with no clock in between.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int GPT_DATA_W = 32;
  localparam int GPT_ADDR_W = 5;

  // byte offsets
  localparam int OFF_CTRL = 0;
  localparam int OFF_LOAD = 4;
  localparam int OFF_CNT  = 8;
  localparam int OFF_STAT = 12;
  localparam int OFF_IE   = 16;

  // bit positions
  localparam int CTRL_RUN  = 0;
  localparam int CTRL_RELD = 1;
  localparam int STAT_OVF  = 0;
  localparam int IE_OVF    = 0;

  typedef struct packed {
    logic ctrl;
    logic load;
    logic cnt;
    logic stat;
    logic ie;
  } gpt_wstb_t;
endpackage

// File: rtl/gpt_rst_sync.sv
module gpt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_an,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_an) begin
    if (!rst_an) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/gpt_regif.sv
module gpt_regif
  import gpt_pkg::*;
#(
  parameter int DATA_W = GPT_DATA_W,
  parameter int ADDR_W = GPT_ADDR_W
) (
  input  logic              sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              run,
  input  logic              reld,
  input  logic [DATA_W-1:0] load,
  input  logic [DATA_W-1:0] cnt,
  input  logic              stat,
  input  logic              ie,
  output gpt_wstb_t         wstb,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(OFF_LOAD);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFF_CNT);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_IE   = ADDR_W'(OFF_IE);

  logic wr_go;

  always_comb begin
    wr_go     = sel & wr_en;
    wstb.ctrl = wr_go & (addr == A_CTRL);
    wstb.load = wr_go & (addr == A_LOAD);
    wstb.cnt  = wr_go & (addr == A_CNT);
    wstb.stat = wr_go & (addr == A_STAT);
    wstb.ie   = wr_go & (addr == A_IE);
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[CTRL_RUN]  = run;
        rdata[CTRL_RELD] = reld;
      end
      A_LOAD:  rdata = load;
      A_CNT:   rdata = cnt;
      A_STAT:  rdata[STAT_OVF] = stat;
      A_IE:    rdata[IE_OVF] = ie;
      default: rdata = '0;
    endcase
  end

  // R12: at most one register strobed per write
  always_comb begin
    assert_one_strobe_R12: assert ($onehot0(wstb));
  end
endmodule

// File: rtl/gpt_count_core.sv
module gpt_count_core
  import gpt_pkg::*;
#(
  parameter int DATA_W = GPT_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_load,
  input  logic              wr_cnt,
  input  logic [DATA_W-1:0] wdata,
  output logic              run_o,
  output logic              reld_o,
  output logic [DATA_W-1:0] load_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic              ovf_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic              run_q, run_d, run_en;
  logic              reld_q, reld_d;
  logic [DATA_W-1:0] load_q, load_d;
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;
  logic              at_top;
  logic              ovf;

  // next state
  always_comb begin
    at_top = &cnt_q;
    ovf    = run_q & at_top & ~wr_cnt;

    reld_d = wdata[CTRL_RELD];
    load_d = wdata;

    run_en = wr_ctrl | (ovf & ~reld_q);
    run_d  = wr_ctrl ? wdata[CTRL_RUN] : 1'b0;

    cnt_en = wr_cnt | run_q;
    if (wr_cnt)      cnt_d = wdata;
    else if (ovf)    cnt_d = reld_q ? load_q : '0;
    else             cnt_d = cnt_q + ONE;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      reld_q <= 1'b0;
      load_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (run_en)  run_q  <= run_d;
      if (wr_ctrl) reld_q <= reld_d;
      if (wr_load) load_q <= load_d;
      if (cnt_en)  cnt_q  <= cnt_d;
    end
  end

  assign run_o  = run_q;
  assign reld_o = reld_q;
  assign load_o = load_q;
  assign cnt_o  = cnt_q;
  assign ovf_o  = ovf;

  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !wr_cnt && !at_top) |=> (cnt_q == $past(cnt_q) + ONE));

  assert_cnt_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_cnt) |=> $stable(cnt_q));

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && at_top && reld_q && !wr_cnt && !wr_ctrl) |=> (run_q && cnt_q == $past(load_q)));

  assert_oneshot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && at_top && !reld_q && !wr_cnt && !wr_ctrl) |=> (!run_q && cnt_q == '0));

  assert_cnt_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_q == $past(wdata)));
endmodule

// File: rtl/gpt_irq_ctl.sv
module gpt_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic wr_stat,
  input  logic wr_ie,
  input  logic stat_bit,
  input  logic ie_bit,
  output logic stat_o,
  output logic ie_o,
  output logic irq_o
);
  logic stat_q, stat_d, stat_en;
  logic ie_q;
  logic clr;

  always_comb begin
    clr     = wr_stat & stat_bit;
    stat_en = ovf | clr;
    stat_d  = ovf;          // a new event outranks the clear (R9)
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      if (stat_en) stat_q <= stat_d;
      if (wr_ie)   ie_q   <= ie_bit;
    end
  end

  assign stat_o = stat_q;
  assign ie_o   = ie_q;
  assign irq_o  = stat_q & ie_q;

  assert_ovf_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> stat_q);

  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ovf) |=> !stat_q);

  assert_stat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ovf) |=> $stable(stat_q));

  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ie && !ie_bit) |=> !irq_o);
endmodule

// File: rtl/gpt_timer.sv
module gpt_timer
  import gpt_pkg::*;
#(
  parameter int DATA_W      = GPT_DATA_W,
  parameter int ADDR_W      = GPT_ADDR_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic              rst_sn;
  gpt_wstb_t         wstb;
  logic              run, reld, ovf, stat, ie;
  logic [DATA_W-1:0] load, cnt;

  gpt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_an (rst_n),
    .rst_sn (rst_sn)
  );

  gpt_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regif (
    .sel   (sel),
    .wr_en (wr_en),
    .addr  (addr),
    .run   (run),
    .reld  (reld),
    .load  (load),
    .cnt   (cnt),
    .stat  (stat),
    .ie    (ie),
    .wstb  (wstb),
    .rdata (rdata)
  );

  gpt_count_core #(.DATA_W(DATA_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_sn),
    .wr_ctrl (wstb.ctrl),
    .wr_load (wstb.load),
    .wr_cnt  (wstb.cnt),
    .wdata   (wdata),
    .run_o   (run),
    .reld_o  (reld),
    .load_o  (load),
    .cnt_o   (cnt),
    .ovf_o   (ovf)
  );

  gpt_irq_ctl u_irq (
    .clk      (clk),
    .rst_n    (rst_sn),
    .ovf      (ovf),
    .wr_stat  (wstb.stat),
    .wr_ie    (wstb.ie),
    .stat_bit (wdata[STAT_OVF]),
    .ie_bit   (wdata[IE_OVF]),
    .stat_o   (stat),
    .ie_o     (ie),
    .irq_o    (irq)
  );

  // R1: nothing pending while held in reset
  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    !rst_sn |-> (!irq && !run));
endmodule

// File: tb/test_gpt_timer.sv
module test_gpt_timer;
  localparam int CLK_P = 10;
  localparam logic [4:0] A_CTRL = 5'h00, A_LOAD = 5'h04, A_CNT = 5'h08,
                         A_STAT = 5'h0C, A_IE = 5'h10;
  localparam logic [31:0] TOP = 32'hFFFF_FFFF;
  // {ticks N, auto-reload, reload value}
  localparam logic [48:0] VEC [0:5] = '{
    {16'd0,  1'b0, 32'h0000_0000},
    {16'd1,  1'b0, 32'h0000_0000},
    {16'd5,  1'b0, 32'hDEAD_0000},
    {16'd12, 1'b0, 32'h0000_0000},
    {16'd3,  1'b1, 32'h0000_1234},
    {16'd0,  1'b1, 32'hABCD_0001}
  };

  logic        clk, rst_n, sel, wr_en, irq;
  logic [4:0]  addr;
  logic [31:0] wdata, rdata, rv;
  logic [15:0] n_i;
  logic        ar_i;
  logic [31:0] ld_i;
  int n_chk = 0, n_fail = 0;

  gpt_timer i_gpt_timer (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic all_zero(input string tag);
    rd(A_CTRL, rv); chk(tag, rv, 0);
    rd(A_LOAD, rv); chk(tag, rv, 0);
    rd(A_CNT,  rv); chk(tag, rv, 0);
    rd(A_STAT, rv); chk(tag, rv, 0);
    rd(A_IE,   rv); chk(tag, rv, 0);
    chk(tag, {31'b0, irq}, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sel = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    all_zero("R1 after reset");

    // table walk: delay, overflow, one-shot / reload outcome
    for (int i = 0; i < 6; i++) begin
      {n_i, ar_i, ld_i} = VEC[i];
      wr(A_CTRL, 0);
      wr(A_STAT, 1);
      wr(A_LOAD, ld_i);
      wr(A_CNT, TOP - {16'b0, n_i});
      wr(A_CTRL, {30'b0, ar_i, 1'b1});          // edge E0
      repeat (n_i) @(negedge clk);              // after EN
      rd(A_STAT, rv); chk("R6 not yet", rv, 0);
      @(negedge clk);                           // after EN+1
      rd(A_STAT, rv); chk("R3/R6 overflow", rv, 1);
      rd(A_CNT, rv);  chk(ar_i ? "R4 reload cnt" : "R5 one-shot cnt", rv, ar_i ? ld_i : 0);
      rd(A_CTRL, rv); chk(ar_i ? "R4 still run" : "R5 run cleared", rv, ar_i ? 3 : 0);
    end

    // R8: write 0 keeps, write 1 clears (status is 1 here)
    wr(A_CTRL, 0);
    wr(A_STAT, 0);
    rd(A_STAT, rv); chk("R8 write0 keeps", rv, 1);
    wr(A_STAT, 1);
    rd(A_STAT, rv); chk("R8 write1 clears", rv, 0);

    // R9: clear lands on the overflow edge
    wr(A_STAT, 0);
    wr(A_CNT, TOP);
    wr(A_CTRL, 1);                              // E0
    wr(A_STAT, 1);                              // E1 = overflow edge
    rd(A_STAT, rv); chk("R9 set beats clear", rv, 1);

    // R2 / R11: counting, write priority, freeze
    wr(A_CTRL, 0);
    wr(A_CNT, 100);
    wr(A_CTRL, 1);                              // E0
    rd(A_CNT, rv); chk("R2 start no step", rv, 100);
    @(negedge clk);
    rd(A_CNT, rv); chk("R2 step", rv, 101);
    wr(A_CNT, 500);
    rd(A_CNT, rv); chk("R11 write wins", rv, 500);
    @(negedge clk);
    rd(A_CNT, rv); chk("R2 step after write", rv, 501);
    wr(A_CTRL, 0);
    rd(A_CNT, rv); chk("R2 stop edge", rv, 502);
    repeat (3) @(negedge clk);
    rd(A_CNT, rv); chk("R2 frozen", rv, 502);
    // restart from the saved count
    wr(A_CTRL, 3);
    @(negedge clk);
    rd(A_CNT, rv); chk("R11 resume saved", rv, 503);

    // R11: counter write on the overflow edge cancels it
    wr(A_CTRL, 0);
    wr(A_STAT, 1);
    wr(A_CNT, TOP);
    wr(A_CTRL, 1);                              // E0
    wr(A_CNT, 7);                               // E1
    rd(A_CNT, rv);  chk("R11 cnt on ovf edge", rv, 7);
    rd(A_STAT, rv); chk("R11 ovf cancelled", rv, 0);

    // R7: period P = 4
    wr(A_CTRL, 0);
    wr(A_LOAD, TOP - 3);
    wr(A_CNT, TOP - 3);
    wr(A_CTRL, 3);                              // E0
    repeat (3) @(negedge clk);
    rd(A_CNT, rv); chk("R7 top at 3", rv, TOP);
    @(negedge clk);
    rd(A_CNT, rv); chk("R7 reload at 4", rv, TOP - 3);
    repeat (3) @(negedge clk);
    rd(A_CNT, rv); chk("R7 top at 7", rv, TOP);
    @(negedge clk);
    rd(A_CNT, rv); chk("R7 reload at 8", rv, TOP - 3);

    // R10: interrupt gating
    wr(A_CTRL, 0);
    wr(A_STAT, 1);
    wr(A_IE, 1);
    rd(A_IE, rv); chk("R10 enable reads", rv, 1);
    chk("R10 no status", {31'b0, irq}, 0);
    wr(A_CNT, TOP);
    wr(A_CTRL, 1);
    @(negedge clk);
    chk("R10 irq up", {31'b0, irq}, 1);
    wr(A_IE, 0);
    chk("R10 masked", {31'b0, irq}, 0);
    wr(A_IE, 1);
    chk("R10 unmasked", {31'b0, irq}, 1);
    wr(A_STAT, 1);
    chk("R10 cleared", {31'b0, irq}, 0);

    // R12: unmapped addresses
    wr(A_LOAD, 32'h5555_AAAA);
    wr(5'h14, TOP);
    wr(5'h02, TOP);
    rd(5'h14, rv);  chk("R12 unmapped reads 0", rv, 0);
    rd(5'h02, rv);  chk("R12 misaligned reads 0", rv, 0);
    rd(A_LOAD, rv); chk("R12 load untouched", rv, 32'h5555_AAAA);
    rd(A_CTRL, rv); chk("R12 ctrl untouched", rv, 0);

    // R1: asynchronous reset mid-run
    wr(A_CTRL, 3);
    #2 rst_n = 1'b0;
    #1 all_zero("R1 async clear");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    all_zero("R1 after release");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule